// File: doc/BRIEF.md
# SAR Track-and-Convert Sequencer

This block is the digital side of a 10-bit successive-approximation converter. It chooses which event starts a conversion and decides when the sample-and-hold follows the input and when it holds it. It then walks a trial code past an external comparator, one bit per SAR clock, and reports busy, done and the finished code. The comparator, the DAC and the input multiplexer are outside the block. Everything runs on the SAR clock.

The sample-and-hold can be controlled in two ways. In the default scheme it follows the input whenever no conversion is running. In the low-power scheme it is idle until a start arrives. An internal start then opens a fixed three-clock tracking window before the bit search. When the external convert-start pin is the trigger, the pin level opens the window directly (low means track) and its rising edge begins the search at once. A sleep request turns tracking off in both schemes.

Top module: `sar_track_conv`

## Requirements
- R1: While reset is held and on the first cycle after it, busy, done, result and dac_code are 0. With lp_track=0 and sleep_req=0, track_en is 1.
- R2: With lp_track=0, track_en is 1 whenever busy is 0 and 0 on every cycle that busy is 1. A conversion started this way keeps busy high for exactly 11 clocks.
- R3: With lp_track=1 and an internal trigger, busy stays high for 14 clocks. track_en is 1 on the first 3 of them and 0 on the other 11. While idle, track_en is 0.
- R4: With lp_track=1 and trig_sel=100, track_en while idle is the inverse of the synchronized ext_cnv level. A rising edge of ext_cnv starts a conversion with no tracking window: busy is high for 11 clocks with track_en 0.
- R5: trig_sel picks the start source. 000 selects sw_start, 001, 010 and 011 select tmr_ovf[0], [1] and [2], 101 selects tmr_ovf[3], and 100 selects the rising edge of ext_cnv. Codes 110 and 111 select nothing. Strobes on sources that are not selected have no effect.
- R6: Bits are resolved from MSB to LSB. The first trial code is 10'h200. A trial bit is kept when cmp_in=1, meaning the input is at or above dac_code. With an ideal comparator, result equals the input code. result changes only on the cycle that busy falls.
- R7: busy rises on the clock edge that samples a selected start. It falls on the edge that latches result. done is set on that same edge and stays 1 until a done_clr pulse clears it. dac_code is 0 whenever no bit trial is in progress.
- R8: A start that arrives while busy=1 is ignored. It neither lengthens the running conversion nor queues another one.
- R9: While sleep_req=1, track_en is 0 in every mode. A tracking window that has already begun still runs its full length.
- R10: ext_cnv goes through two synchronizer flops before edge detection. busy is seen high after the third rising clock edge following the pin's rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | SAR clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_sel | input | 3 | Start-source select code |
| lp_track | input | 1 | 1 selects low-power tracking |
| sw_start | input | 1 | Software start strobe |
| tmr_ovf | input | 4 | Timer overflow strobes |
| ext_cnv | input | 1 | Asynchronous external convert-start pin |
| sleep_req | input | 1 | Sleep/standby request, turns tracking off |
| cmp_in | input | 1 | Comparator output: 1 when the input is at or above dac_code |
| done_clr | input | 1 | Clears the done flag |
| track_en | output | 1 | Sample-and-hold tracks while 1 |
| dac_code | output | 10 | Trial code driven to the DAC |
| busy | output | 1 | Conversion (including any tracking window) in progress |
| done | output | 1 | Sticky completion flag |
| result | output | 10 | Last converted code |

## Verification
The hardest cases to reach from the ports are a start that arrives in the middle of a running conversion, and a sleep request that falls inside an internal tracking window. In the first, the window must neither stretch nor restart the conversion. In the second, the window must still be counted while track_en stays low. The bench reaches both by counting clocks from the cycle busy is first seen high. It raises sw_start on a chosen busy cycle, and it holds sleep_req across a low-power start. It then checks the busy length, the position of every track_en cycle and the result. A behavioral comparator is driven from a chosen input code, so each bit decision follows from dac_code alone.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Start-source select codes
    localparam logic [2:0] SRC_SW  = 3'b000;
    localparam logic [2:0] SRC_T0  = 3'b001;
    localparam logic [2:0] SRC_T1  = 3'b010;
    localparam logic [2:0] SRC_T2  = 3'b011;
    localparam logic [2:0] SRC_EXT = 3'b100;
    localparam logic [2:0] SRC_T3  = 3'b101;

    localparam int NUM_TMR = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_CONV  = 2'd2,
        ST_LATCH = 2'd3
    } sar_state_e;

    typedef struct packed {
        logic start;     // one-cycle start request from the selected source
        logic ext_mode;  // external pin is the selected source
        logic pin_lvl;   // synchronized pin level
    } trig_info_t;

    function automatic logic src_is_ext(input logic [2:0] sel);
        return sel == SRC_EXT;
    endfunction

endpackage

// File: rtl/sar_trig_sel.sv
module sar_trig_sel
    import sar_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         sel,
    input  logic               sw_start,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               ext_pin,
    output trig_info_t         info
);

    // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], ext_pin};
    end

    logic pin_sync, pin_rise;
    assign pin_sync = chain[SYNC_STAGES-1];
    assign pin_rise = pin_sync & ~chain[SYNC_STAGES];

    always_comb begin
        info.ext_mode = src_is_ext(sel);
        info.pin_lvl  = pin_sync;
        case (sel)
            SRC_SW:  info.start = sw_start;
            SRC_T0:  info.start = tmr_ovf[0];
            SRC_T1:  info.start = tmr_ovf[1];
            SRC_T2:  info.start = tmr_ovf[2];
            SRC_T3:  info.start = tmr_ovf[3];
            SRC_EXT: info.start = pin_rise;
            default: info.start = 1'b0;
        endcase
    end

endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int TRACK_CLKS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             add_window,
    input  logic             cmp_in,
    input  logic             done_clr,
    output sar_state_e       state,
    output logic [RES_W-1:0] dac_code,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);

    localparam int IDXW = $clog2(RES_W);
    localparam int TCW  = $clog2(TRACK_CLKS + 1);

    logic [RES_W-1:0] sar_q;
    logic [IDXW-1:0]  bit_idx;
    logic [TCW-1:0]   win_cnt;
    logic [RES_W-1:0] trial;

    assign trial    = sar_q | (RES_W'(1) << bit_idx);
    assign dac_code = (state == ST_CONV) ? trial : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sar_q   <= '0;
            bit_idx <= '0;
            win_cnt <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            if (done_clr) done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        busy    <= 1'b1;
                        sar_q   <= '0;
                        bit_idx <= IDXW'(RES_W - 1);
                        win_cnt <= '0;
                        state   <= add_window ? ST_TRACK : ST_CONV;
                    end
                end
                ST_TRACK: begin
                    if (win_cnt == TCW'(TRACK_CLKS - 1)) state <= ST_CONV;
                    else win_cnt <= win_cnt + TCW'(1);
                end
                ST_CONV: begin
                    if (cmp_in) sar_q <= trial;
                    if (bit_idx == '0) state <= ST_LATCH;
                    else bit_idx <= bit_idx - IDXW'(1);
                end
                ST_LATCH: begin
                    result <= sar_q;
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: a sampled start raises busy on the next edge
    assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> busy);

    // R8: busy cannot drop before the result latch step
    assert_busy_held_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && state != ST_LATCH) |=> busy);

    // R7: done is sticky until cleared
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !done_clr) |=> done);

    // R6: the first trial code is the MSB alone
    assert_msb_first_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV && $past(state) != ST_CONV) |-> dac_code == (RES_W'(1) << (RES_W - 1)));

endmodule

// File: rtl/sar_track_gate.sv
module sar_track_gate
    import sar_seq_pkg::*;
(
    input  sar_state_e state,
    input  logic       lp_track,
    input  logic       ext_mode,
    input  logic       pin_lvl,
    input  logic       sleep_req,
    output logic       track_en
);

    always_comb begin
        if (sleep_req) begin
            track_en = 1'b0;
        end else begin
            case (state)
                ST_TRACK: track_en = 1'b1;
                ST_IDLE:  track_en = !lp_track || (ext_mode && !pin_lvl);
                default:  track_en = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sar_track_conv.sv
module sar_track_conv
    import sar_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int TRACK_CLKS  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         trig_sel,
    input  logic               lp_track,
    input  logic               sw_start,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               ext_cnv,
    input  logic               sleep_req,
    input  logic               cmp_in,
    input  logic               done_clr,
    output logic               track_en,
    output logic [RES_W-1:0]   dac_code,
    output logic               busy,
    output logic               done,
    output logic [RES_W-1:0]   result
);

    trig_info_t trig;
    sar_state_e state;
    logic       add_window;

    sar_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk(clk), .rst(rst), .sel(trig_sel), .sw_start(sw_start),
        .tmr_ovf(tmr_ovf), .ext_pin(ext_cnv), .info(trig)
    );

    // Low-power tracking inserts a window only for internal sources
    assign add_window = lp_track && !trig.ext_mode;

    sar_core #(.RES_W(RES_W), .TRACK_CLKS(TRACK_CLKS)) u_core (
        .clk(clk), .rst(rst), .start(trig.start), .add_window(add_window),
        .cmp_in(cmp_in), .done_clr(done_clr), .state(state),
        .dac_code(dac_code), .busy(busy), .done(done), .result(result)
    );

    sar_track_gate u_gate (
        .state(state), .lp_track(lp_track), .ext_mode(trig.ext_mode),
        .pin_lvl(trig.pin_lvl), .sleep_req(sleep_req), .track_en(track_en)
    );

    // R9: sleep forces the hold
    assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> !track_en);

    // R2: no tracking while a bit trial is driven
    assert_trial_no_track_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && dac_code != '0) |-> !track_en);

    // R6: result moves only as busy falls
    assert_result_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(result));

    // R7: finishing a conversion leaves done set
    assert_done_on_finish_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

// File: tb/sar_track_conv_test.sv
`timescale 1ns/1ps
module sar_track_conv_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] trig_sel = 3'b000;
    logic       lp_track = 1'b0;
    logic       sw_start = 1'b0;
    logic [3:0] tmr_ovf = 4'b0;
    logic       ext_cnv = 1'b0;
    logic       sleep_req = 1'b0;
    logic       cmp_in;
    logic       done_clr = 1'b0;
    logic       track_en;
    logic [9:0] dac_code;
    logic       busy;
    logic       done;
    logic [9:0] result;

    int checks = 0;
    int fails  = 0;
    logic [9:0] vin = 10'd0;

    always #2.5 clk = ~clk;

    // Ideal comparator: input at or above the trial code
    assign cmp_in = (vin >= dac_code);

    sar_track_conv uut (
        .clk(clk), .rst(rst), .trig_sel(trig_sel), .lp_track(lp_track),
        .sw_start(sw_start), .tmr_ovf(tmr_ovf), .ext_cnv(ext_cnv),
        .sleep_req(sleep_req), .cmp_in(cmp_in), .done_clr(done_clr),
        .track_en(track_en), .dac_code(dac_code), .busy(busy),
        .done(done), .result(result)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) sw_start = 1'b1;
        else tmr_ovf[which-1] = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        tmr_ovf  = '0;
    endtask

    task automatic pulse_all();
        @(negedge clk);
        sw_start = 1'b1;
        tmr_ovf  = '1;
        @(negedge clk);
        sw_start = 1'b0;
        tmr_ovf  = '0;
    endtask

    // Starts at a sample where busy is already high
    task automatic measure(input int ntrk, output int nbusy, output int early,
                           output int late, output int trial0);
        nbusy = 0; early = 0; late = 0; trial0 = -1;
        while (busy && nbusy < 100) begin
            if (track_en) begin
                if (nbusy < ntrk) early++;
                else late++;
            end
            if (nbusy == ntrk) trial0 = int'(dac_code);
            nbusy++;
            @(negedge clk);
        end
    endtask

    task automatic clear_done();
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 result", int'(result), 0);
        chk("R1 dac_code", int'(dac_code), 0);
        chk("R1 track_en", int'(track_en), 1);
    endtask

    task automatic t_default_sw();
        int vals[6] = '{0, 1023, 512, 511, 682, 341};
        int nb, e, l, t0;
        lp_track = 1'b0;
        trig_sel = 3'b000;
        foreach (vals[i]) begin
            vin = 10'(vals[i]);
            @(negedge clk);
            chk("R2 idle track", int'(track_en), 1);
            pulse(0);
            chk("R7 busy after start", int'(busy), 1);
            measure(0, nb, e, l, t0);
            chk("R2 busy length", nb, 11);
            chk("R2 track while busy", e + l, 0);
            chk("R6 first trial", t0, 512);
            chk("R6 result", int'(result), vals[i]);
            chk("R7 done set", int'(done), 1);
            chk("R7 dac idle", int'(dac_code), 0);
            chk("R2 track after", int'(track_en), 1);
            repeat (4) @(negedge clk);
            chk("R7 done held", int'(done), 1);
            clear_done();
            chk("R7 done cleared", int'(done), 0);
        end
    endtask

    task automatic t_lowpower_int();
        int nb, e, l, t0;
        lp_track = 1'b1;
        trig_sel = 3'b001;
        vin = 10'd777;
        @(negedge clk);
        chk("R3 idle no track", int'(track_en), 0);
        pulse(1);
        measure(3, nb, e, l, t0);
        chk("R3 busy length", nb, 14);
        chk("R3 window cycles", e, 3);
        chk("R3 track after window", l, 0);
        chk("R6 first trial lp", t0, 512);
        chk("R6 result lp", int'(result), 777);
        clear_done();
    endtask

    task automatic t_trig_select();
        logic [2:0] codes[5] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b101};
        int         srcs[5]  = '{0, 1, 2, 3, 4};
        int nb, e, l, t0;
        lp_track = 1'b0;
        vin = 10'd100;
        foreach (codes[i]) begin
            trig_sel = codes[i];
            pulse(srcs[i] == 0 ? 1 : 0);
            chk("R5 other source ignored", int'(busy), 0);
            pulse(srcs[i]);
            chk("R5 selected source starts", int'(busy), 1);
            measure(0, nb, e, l, t0);
            chk("R5 result", int'(result), 100);
        end
        trig_sel = 3'b110;
        pulse_all();
        chk("R5 code 110 no start", int'(busy), 0);
        trig_sel = 3'b111;
        pulse_all();
        chk("R5 code 111 no start", int'(busy), 0);
        clear_done();
    endtask

    task automatic t_ext(input logic lp);
        int nb, e, l, t0;
        lp_track = lp;
        trig_sel = 3'b100;
        vin = 10'd259;
        ext_cnv = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 pin low tracks", int'(track_en), 1);
        ext_cnv = 1'b1;
        @(negedge clk);
        chk("R10 busy after edge 1", int'(busy), 0);
        @(negedge clk);
        chk("R10 busy after edge 2", int'(busy), 0);
        chk(lp ? "R4 pin high holds" : "R2 idle tracks with pin high", int'(track_en), lp ? 0 : 1);
        @(negedge clk);
        chk("R10 busy after edge 3", int'(busy), 1);
        measure(0, nb, e, l, t0);
        chk("R4 busy length", nb, 11);
        chk("R4 no track while busy", e + l, 0);
        chk("R4 result", int'(result), 259);
        ext_cnv = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 no second start", int'(busy), 0);
        clear_done();
    endtask

    task automatic t_busy_ignore();
        int n = 0;
        int late_busy = 0;
        lp_track = 1'b0;
        trig_sel = 3'b000;
        vin = 10'd300;
        pulse(0);
        while (busy && n < 100) begin
            sw_start = (n == 4);
            n++;
            @(negedge clk);
        end
        sw_start = 1'b0;
        chk("R8 busy length unchanged", n, 11);
        chk("R8 result", int'(result), 300);
        repeat (5) begin
            @(negedge clk);
            if (busy) late_busy++;
        end
        chk("R8 no queued start", late_busy, 0);
        clear_done();
    endtask

    task automatic t_sleep();
        int nb, e, l, t0;
        lp_track = 1'b0;
        trig_sel = 3'b000;
        sleep_req = 1'b1;
        vin = 10'd45;
        @(negedge clk);
        chk("R9 sleep blocks idle track", int'(track_en), 0);
        lp_track = 1'b1;
        pulse(0);
        measure(3, nb, e, l, t0);
        chk("R9 window still timed", nb, 14);
        chk("R9 no track in window", e + l, 0);
        chk("R9 result", int'(result), 45);
        sleep_req = 1'b0;
        lp_track = 1'b0;
        @(negedge clk);
        chk("R9 wake tracks", int'(track_en), 1);
        clear_done();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_default_sw();
        t_lowpower_int();
        t_trig_select();
        t_ext(1'b1);
        t_ext(1'b0);
        t_busy_ignore();
        t_sleep();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule